// File: doc/BRIEF.md
# Short-Key Streaming Hash Pipeline

This block computes a 32-bit multiplicative mixing hash (the MurmurHash2 algorithm) over keys of zero to three bytes, such as compact word identifiers. Each input beat carries up to three key bytes, a 2-bit byte count and a 32-bit seed. The beat enters under a valid/ready handshake. The hash comes out in the order the keys went in, with its own valid flag, after a fixed pipeline latency.

The datapath is five register stages, and each stage does one operation. The first stage folds the length into the seed and XORs in the key bytes that lie below the length. The second stage does the tail multiply, or skips it for an empty key. The third stage does an XOR with a right shift by 13. The fourth stage does a second multiply. The fifth stage does an XOR with a right shift by 15. Every shift is a fixed rewiring and finishes within its cycle.

Back-pressure from the consumer freezes every stage together. The input ready signal reports that freeze, so no beat is dropped and no beat is duplicated.

Top module: `mh_short_hash`

## Requirements
- R1: Each multiply uses the constant 0x5bd1e995 and keeps only the low 32 bits of the product.
- R2: The working hash begins as the seed XOR the byte count taken from `in_len`. For a 1-byte key with seed 0 and key byte 0, the first stage therefore holds the value 1.
- R3: For length 3, the first stage XORs in byte 2 shifted left by 16, byte 1 shifted left by 8, and byte 0. The tail multiply follows. Byte 0 is `in_key[7:0]`, byte 1 is `in_key[15:8]` and byte 2 is `in_key[23:16]`.
- R4: For length 2, only bytes 1 and 0 are XORed in before the tail multiply. For length 1, only byte 0 is XORed in before it.
- R5: For length 0, no key byte is mixed in and the tail multiply is skipped. Length 0 with seed 0 gives a hash of 0.
- R6: The final mix runs in this order: XOR with the value shifted right by 13, then multiply, then XOR with the value shifted right by 15.
- R7: A synchronous active-high `rst` clears every stage valid flag. `out_valid` is low from the first edge under reset and stays low until a new key is accepted.
- R8: A key accepted on a rising edge (`in_valid` and `in_ready` both high) appears on `out_hash` with `out_valid` high just after the fifth rising edge, counting the accepting edge as the first. With `out_ready` held high, one key is accepted per cycle and the results leave in input order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid` and `out_hash` hold steady. Under any pattern of back-pressure, every accepted key yields exactly one result, in order.
- R10: Key bytes at or above the given length have no effect on the result, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Pipeline can take a beat this cycle |
| in_key | input | 24 | Key bytes; byte 0 in bits 7:0 |
| in_len | input | 2 | Key length in bytes, 0 to 3 |
| in_seed | input | 32 | Hash seed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hash | output | 32 | Hash result |

## Verification
Each result is due just after the fifth rising edge, counting the edge that accepted its key. The bench drives and samples on falling edges. A key driven at falling edge i is therefore compared at falling edge i+5. In single-key tests, the bench also confirms that `out_valid` stays low on the four falling edges before that.

Under random back-pressure, expectations are pushed and popped at the falling edge that precedes each handshake edge. The bench samples there, after the combinational ready has settled, so each result is matched to the exact key whose transfer that edge completes.

// File: rtl/mh_pkg.sv
package mh_pkg;
  localparam int HASH_W    = 32;
  localparam int LEN_W     = 2;
  localparam int KEY_BYTES = 3;
  localparam int KEY_W     = 8 * KEY_BYTES;

  typedef struct packed {
    logic              vld;
    logic              mul_en;
    logic [HASH_W-1:0] h;
  } mh_beat_t;
endpackage

// File: rtl/mh_tail_stage.sv
module mh_tail_stage
  import mh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic [KEY_W-1:0]  key,
  input  logic [LEN_W-1:0]  len,
  input  logic [HASH_W-1:0] seed,
  output mh_beat_t          q
);
  logic [HASH_W-1:0] fold;

  always_comb begin
    fold = seed ^ {{(HASH_W-LEN_W){1'b0}}, len};
    for (int b = 0; b < KEY_BYTES; b++) begin
      if (b < int'(len))
        fold = fold ^ ({{(HASH_W-8){1'b0}}, key[8*b +: 8]} << (8*b));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= '{vld: in_valid, mul_en: (len != '0), h: fold};
    end
  end

  // An empty key leaves only the seed (XOR zero) in the first stage (R5)
  p_empty_seed_r5: assert property (@(posedge clk) disable iff (rst)
    en && in_valid && (len == '0) |=> q.h == $past(seed));
endmodule

// File: rtl/mh_mul_stage.sv
module mh_mul_stage
  import mh_pkg::*;
#(
  parameter logic [HASH_W-1:0] MULT_K   = 32'h5bd1e995,
  parameter bit                USE_FLAG = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  mh_beat_t d,
  output mh_beat_t q
);
  logic [HASH_W-1:0] prod;
  logic              do_mul;

  assign prod = d.h * MULT_K;

  generate
    if (USE_FLAG) begin : g_gated
      assign do_mul = d.mul_en;
    end else begin : g_always
      assign do_mul = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q.vld    <= d.vld;
      q.mul_en <= d.mul_en;
      q.h      <= do_mul ? prod : d.h;
    end
  end

  // An odd constant keeps the low bit of the hash (R1)
  p_lsb_kept_r1: assert property (@(posedge clk) disable iff (rst)
    en && d.vld |=> q.h[0] == $past(d.h[0]));

  // The tail multiply is bypassed for empty keys (R5)
  p_skip_mul_r5: assert property (@(posedge clk) disable iff (rst)
    en && d.vld && USE_FLAG && !d.mul_en |=> q.h == $past(d.h));

  // Stages only advance on enable (R9)
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> q == $past(q));
endmodule

// File: rtl/mh_xs_stage.sv
module mh_xs_stage
  import mh_pkg::*;
#(
  parameter int SHIFT = 13
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  mh_beat_t d,
  output mh_beat_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q.vld    <= d.vld;
      q.mul_en <= d.mul_en;
      q.h      <= d.h ^ (d.h >> SHIFT);
    end
  end

  // A right XOR-shift leaves the top SHIFT bits unchanged (R6)
  p_top_kept_r6: assert property (@(posedge clk) disable iff (rst)
    en && d.vld |=> q.h[HASH_W-1 -: SHIFT] == $past(d.h[HASH_W-1 -: SHIFT]));
endmodule

// File: rtl/mh_short_hash.sv
module mh_short_hash
  import mh_pkg::*;
#(
  parameter logic [HASH_W-1:0] MULT_K  = 32'h5bd1e995,
  parameter int                SHIFT_A = 13,
  parameter int                SHIFT_B = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [HASH_W-1:0] in_seed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HASH_W-1:0] out_hash
);
  mh_beat_t s1, s2, s3, s4, s5;
  logic     adv;

  assign adv      = !s5.vld || out_ready;
  assign in_ready = adv;

  mh_tail_stage u_tail (
    .clk(clk), .rst(rst), .en(adv), .in_valid(in_valid),
    .key(in_key), .len(in_len), .seed(in_seed), .q(s1)
  );

  mh_mul_stage #(.MULT_K(MULT_K), .USE_FLAG(1'b1)) u_mul_tail (
    .clk(clk), .rst(rst), .en(adv), .d(s1), .q(s2)
  );

  mh_xs_stage #(.SHIFT(SHIFT_A)) u_xs_a (
    .clk(clk), .rst(rst), .en(adv), .d(s2), .q(s3)
  );

  mh_mul_stage #(.MULT_K(MULT_K), .USE_FLAG(1'b0)) u_mul_fin (
    .clk(clk), .rst(rst), .en(adv), .d(s3), .q(s4)
  );

  mh_xs_stage #(.SHIFT(SHIFT_B)) u_xs_b (
    .clk(clk), .rst(rst), .en(adv), .d(s4), .q(s5)
  );

  assign out_valid = s5.vld;
  assign out_hash  = s5.h;

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> !out_valid);

  p_ready_low_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_hash));
endmodule

// File: tb/mh_short_hash_bench.sv
`timescale 1ns/1ps
module mh_short_hash_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_key = '0;
  logic [1:0]  in_len = '0;
  logic [31:0] in_seed = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_hash;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mh_short_hash u_mh_short_hash (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_len(in_len), .in_seed(in_seed),
    .out_valid(out_valid), .out_ready(out_ready), .out_hash(out_hash)
  );

  function automatic logic [31:0] ref_hash(logic [23:0] k, logic [1:0] n, logic [31:0] s);
    logic [31:0] h;
    h = s ^ {30'd0, n};
    if (n >= 2'd3) h = h ^ ({24'd0, k[23:16]} << 16);
    if (n >= 2'd2) h = h ^ ({24'd0, k[15:8]} << 8);
    if (n >= 2'd1) begin
      h = h ^ {24'd0, k[7:0]};
      h = h * 32'h5bd1e995;
    end
    h = h ^ (h >> 13);
    h = h * 32'h5bd1e995;
    h = h ^ (h >> 15);
    return h;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R7 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;
  endtask

  // Single key, checks latency and value
  task automatic t_one(logic [23:0] k, logic [1:0] n, logic [31:0] s, logic [31:0] exp, string req);
    @(negedge clk);
    in_valid = 1'b1; in_key = k; in_len = n; in_seed = s;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (i < 5)
        chk(out_valid == 1'b0, {req, " R8 early valid"}, {31'd0, out_valid}, 32'd0);
    end
    chk(out_valid == 1'b1, {req, " R8 valid at edge 5"}, {31'd0, out_valid}, 32'd1);
    chk(out_hash == exp, req, out_hash, exp);
  endtask

  task automatic t_lengths();
    t_one(24'h000000, 2'd0, 32'd0, 32'd0, "R5 len0 seed0");
    for (int r = 0; r < 3; r++) begin
      logic [31:0] s;
      logic [23:0] k;
      s = $urandom; k = $urandom;
      t_one(k, 2'd0, s, ref_hash(k, 2'd0, s), "R5 R2 R6 len0");
      t_one(k, 2'd1, s, ref_hash(k, 2'd1, s), "R4 R2 R1 len1");
      t_one(k, 2'd2, s, ref_hash(k, 2'd2, s), "R4 R1 len2");
      t_one(k, 2'd3, s, ref_hash(k, 2'd3, s), "R3 R1 R6 len3");
    end
  endtask

  task automatic t_ignore_high();
    t_one(24'hFFFFAB, 2'd1, 32'h1234_5678, ref_hash(24'h0000AB, 2'd1, 32'h1234_5678), "R10 len1 high bytes");
    t_one(24'h5AC3E1, 2'd2, 32'h0BAD_F00D, ref_hash(24'h00C3E1, 2'd2, 32'h0BAD_F00D), "R10 len2 high byte");
    t_one(24'hFFFFFF, 2'd0, 32'hCAFE_0001, ref_hash(24'h000000, 2'd0, 32'hCAFE_0001), "R10 len0 all bytes");
  endtask

  // Back-to-back keys with out_ready high
  task automatic t_stream();
    logic [31:0] exp[16];
    out_ready = 1'b1;
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      if (i >= 5) begin
        chk(out_valid == 1'b1, "R8 stream valid", {31'd0, out_valid}, 32'd1);
        chk(out_hash == exp[i-5], "R8 stream order", out_hash, exp[i-5]);
      end
      if (i < 16) begin
        in_valid = 1'b1; in_key = $urandom; in_len = 2'(i); in_seed = $urandom;
        exp[i] = ref_hash(in_key, in_len, in_seed);
        chk(in_ready == 1'b1, "R8 accept each cycle", {31'd0, in_ready}, 32'd1);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  // Random back-pressure scoreboard
  task automatic t_stall();
    logic [31:0] exp[40];
    int sent = 0;
    int got = 0;
    int cyc = 0;
    while (got < 40 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      in_valid  = (sent < 40) && ($urandom % 4 != 0);
      in_key    = $urandom; in_len = 2'($urandom); in_seed = $urandom;
      out_ready = ($urandom % 3 != 0);
      #1;
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R9 ready low on stall", {31'd0, in_ready}, 32'd0);
      if (in_valid && in_ready) begin
        exp[sent] = ref_hash(in_key, in_len, in_seed);
        sent++;
      end
      if (out_valid && out_ready) begin
        chk(got < sent, "R9 no extra result", got, sent);
        if (got < 40) chk(out_hash == exp[got], "R9 stall order", out_hash, exp[got]);
        got++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    chk(got == 40, "R9 all results delivered", got, 32'd40);
  endtask

  // Reset mid-stream drops in-flight beats
  task automatic t_mid_reset();
    @(negedge clk);
    in_valid = 1'b1; in_len = 2'd3; in_key = 24'h010203; in_seed = 32'h5;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R7 flushed by reset", {31'd0, out_valid}, 32'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_lengths();
    t_ignore_high();
    t_stream();
    t_stall();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule